// File: doc/BRIEF.md
# Trigger-Centred Snapshot Capture Buffer

This block holds a fixed window of samples with the trigger at its centre. Once armed, it writes every accepted sample into a ring memory of `2*HALF` entries. It keeps doing this until a trigger arrives together with a sample. From the trigger sample on, it takes exactly `HALF` samples, counting the trigger sample itself. It then freezes and raises `done`. At that point the ring holds `HALF` samples from before the trigger and `HALF` samples from the trigger onward.

The `valid` flag reports whether the frozen window can be used. A window is rejected in any of these cases:
- no trigger arrived before the run was stopped;
- fewer than `HALF` samples came before the trigger (too close to the start of the trace);
- the run stopped before the post-trigger half was full (too close to the end of the trace);
- the reported main-trace sample count is below `HALF`.

The production setting is `HALF = 8192`, which gives a 16384-entry window. The default parameter value is smaller so that elaboration stays light.

Readback takes an offset into the window, in time order. Offset 0 is the oldest retained sample and offset `HALF` is the trigger sample. The block adds the trigger's buffer index and subtracts `HALF` modulo the ring size, so the caller never handles the wrap.

Top module: `snap_capture`

## Requirements
- R1: After reset, `done`, `valid` and `trig_index` are all 0, and no sample is stored until `arm` is pulsed.
- R2: A cycle with `arm` high clears `done` and `valid` in the following cycle and restarts the write index at 0. A sample presented in the arm cycle itself is not stored, and `arm` takes priority over every other input, including in mid-capture.
- R3: A trigger counts only when `trig` and `smp_vld` are high in the same cycle while waiting for it. `trig_index` then becomes that sample's buffer index, which is the number of samples accepted since arm, modulo `2*HALF`. A `trig` without `smp_vld` is ignored.
- R4: `done` rises in the cycle after the `HALF`-th accepted sample, counting the trigger sample as the first, and not before.
- R5: `valid` is 0 when fewer than `HALF` samples were accepted before the trigger sample; exactly `HALF` is enough.
- R6: A `stop` pulse before the post-trigger half is full, including before any trigger, ends the capture: `done` rises the next cycle with `valid` 0.
- R7: `main_count` is sampled in the cycle that completes the capture; a value below `HALF` makes `valid` 0, and a value of exactly `HALF` is accepted.
- R8: `rd_data` shows, one cycle after `rd_ofs` is applied, the sample at window position `rd_ofs`, i.e. the one accepted `HALF - rd_ofs` samples before the trigger sample (position `HALF` is the trigger sample).
- R9: While `done` is high and `arm` is low, samples, `trig` and `stop` are ignored: `done`, `valid`, `trig_index` and the stored window all hold.
- R10: `valid` is never high while `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Starts a new capture, clearing the previous result |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | DW | Sample value |
| trig | input | 1 | Trigger pulse, qualified by `smp_vld` |
| stop | input | 1 | Main run has ended |
| main_count | input | CW | Number of main-trace samples captured |
| rd_ofs | input | log2(2*HALF) | Time-ordered readback offset |
| rd_data | output | DW | Readback sample, one cycle latency |
| done | output | 1 | Capture finished, by fill or by stop |
| valid | output | 1 | Finished window is usable |
| trig_index | output | log2(2*HALF) | Buffer index of the trigger sample |

## Verification
A fault in the write index shows up at `trig_index` as soon as `done` rises, and it also shows up as a rotated readback in which the trigger value does not sit at offset `HALF`. An off-by-one in the pre-fill or post-fill counter moves the rise of `done` by one sample, or flips `valid` at the exact-`HALF` boundaries. Rows that arrive with exactly `HALF` pre-samples, or with `main_count == HALF`, expose such a fault in the first cycle after completion. Writes that leak past completion are caught by reading the window back after extra samples and triggers have been applied.

// File: rtl/snap_pkg.sv
package snap_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_POST = 2'd2,
    PH_DONE = 2'd3
  } phase_t;

  // Window acceptance: both halves full and the main trace long enough.
  function automatic logic snap_ok(input logic pre_full,
                                   input logic post_full,
                                   input logic main_ok);
    return pre_full & post_full & main_ok;
  endfunction

endpackage

// File: rtl/snap_store.sv
module snap_store #(
  parameter int DW = 8,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] ring [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ring[waddr] <= wdata;
    rdata <= ring[raddr];
  end
endmodule

// File: rtl/snap_addr.sv
module snap_addr #(
  parameter int HALF = 1024,
  parameter int AW   = 11
) (
  input  logic [AW-1:0] tidx,
  input  logic [AW-1:0] ofs,
  output logic [AW-1:0] raddr
);
  // Window offset to ring index; the truncation to AW bits is the modulo.
  function automatic logic [AW-1:0] win_to_ring(input logic [AW-1:0] t,
                                                input logic [AW-1:0] o);
    return t - AW'(HALF) + o;
  endfunction

  assign raddr = win_to_ring(tidx, ofs);
endmodule

// File: rtl/snap_ctrl.sv
module snap_ctrl
  import snap_pkg::*;
#(
  parameter int HALF = 1024,
  parameter int AW   = 11,
  parameter int CW   = 32,
  localparam int PW  = $clog2(HALF + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          smp_vld,
  input  logic          trig,
  input  logic          stop,
  input  logic [CW-1:0] main_count,
  output logic          wr_en,
  output logic [AW-1:0] wr_idx,
  output logic [AW-1:0] trig_idx,
  output logic          done,
  output logic          valid,
  output logic [PW-1:0] post_cnt,
  output logic          trig_evt
);
  phase_t        phase;
  logic [PW-1:0] pre_cnt;
  logic [PW-1:0] post_inc;
  logic          busy, accept, fill_done, stop_evt, pre_full, pre_ok, main_ok;

  assign busy      = (phase == PH_PRE) || (phase == PH_POST);
  assign accept    = smp_vld && busy && !arm;
  assign trig_evt  = accept && trig && (phase == PH_PRE);
  assign post_inc  = (phase == PH_PRE) ? PW'(1) : post_cnt + PW'(1);
  assign fill_done = (trig_evt || (accept && phase == PH_POST)) &&
                     (post_inc == PW'(HALF));
  assign stop_evt  = stop && busy && !arm && !fill_done;
  assign pre_full  = (pre_cnt == PW'(HALF));
  assign main_ok   = (main_count >= CW'(HALF));
  assign wr_en     = accept;

  always_ff @(posedge clk) begin
    if (!rst_n || arm) begin
      phase    <= rst_n ? PH_PRE : PH_IDLE;
      wr_idx   <= '0;
      pre_cnt  <= '0;
      post_cnt <= '0;
      trig_idx <= '0;
      pre_ok   <= 1'b0;
      done     <= 1'b0;
      valid    <= 1'b0;
    end else begin
      if (accept) wr_idx <= wr_idx + AW'(1);
      if (accept && phase == PH_PRE && !trig_evt && !pre_full)
        pre_cnt <= pre_cnt + PW'(1);
      if (trig_evt) begin
        trig_idx <= wr_idx;
        pre_ok   <= pre_full;
        phase    <= PH_POST;
      end
      if (trig_evt || (accept && phase == PH_POST))
        post_cnt <= post_inc;
      if (fill_done) begin
        phase <= PH_DONE;
        done  <= 1'b1;
        valid <= snap_ok(trig_evt ? pre_full : pre_ok, 1'b1, main_ok);
      end else if (stop_evt) begin
        phase <= PH_DONE;
        done  <= 1'b1;
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/snap_capture.sv
module snap_capture #(
  parameter int DW   = 8,
  parameter int HALF = 1024,
  parameter int CW   = 32,
  localparam int DEPTH = 2 * HALF,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = $clog2(HALF + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          smp_vld,
  input  logic [DW-1:0] smp_data,
  input  logic          trig,
  input  logic          stop,
  input  logic [CW-1:0] main_count,
  input  logic [AW-1:0] rd_ofs,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic          valid,
  output logic [AW-1:0] trig_index
);
  logic          wr_en;
  logic [AW-1:0] wr_idx;
  logic [AW-1:0] rd_addr;
  logic [PW-1:0] post_cnt;
  logic          trig_evt;

  snap_ctrl #(.HALF(HALF), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .smp_vld(smp_vld), .trig(trig),
    .stop(stop), .main_count(main_count), .wr_en(wr_en), .wr_idx(wr_idx),
    .trig_idx(trig_index), .done(done), .valid(valid),
    .post_cnt(post_cnt), .trig_evt(trig_evt)
  );

  snap_addr #(.HALF(HALF), .AW(AW)) u_addr (
    .tidx(trig_index), .ofs(rd_ofs), .raddr(rd_addr)
  );

  snap_store #(.DW(DW), .AW(AW)) u_store (
    .clk(clk), .we(wr_en), .waddr(wr_idx), .wdata(smp_data),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/snap_capture_chk.sv
module snap_capture_chk #(
  parameter int HALF = 1024,
  parameter int AW   = 11,
  parameter int PW   = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm,
  input logic          done,
  input logic          valid,
  input logic [AW-1:0] trig_index,
  input logic          wr_en,
  input logic [PW-1:0] post_cnt,
  input logic          trig_evt
);
  assert_valid_needs_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> done);

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> done);

  assert_tidx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> $stable(trig_index));

  assert_no_write_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en);

  assert_arm_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!done && !valid));

  assert_post_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    post_cnt <= PW'(HALF));

  assert_trig_while_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_evt |-> !done);
endmodule

bind snap_capture snap_capture_chk #(.HALF(HALF), .AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .done(done), .valid(valid),
  .trig_index(trig_index), .wr_en(wr_en), .post_cnt(post_cnt),
  .trig_evt(trig_evt)
);

// File: tb/snap_capture_bench.sv
module snap_capture_bench;
  localparam int DW = 8, HALF = 8, CW = 16, DEPTH = 2 * HALF, AW = 4;

  typedef struct packed {
    logic [7:0]  pre;
    logic [7:0]  post;
    logic        trg;
    logic        gap;
    logic [15:0] mcnt;
    logic        expv;
    logic [7:0]  seed;
  } row_t;

  // pre, post (incl. trigger sample; <HALF means stop), trg, gap, main_count, exp valid, seed
  localparam row_t ROWS [8] = '{
    '{8'd8,  8'd8, 1'b1, 1'b0, 16'd100, 1'b1, 8'h10},  // R5 exact pre
    '{8'd20, 8'd8, 1'b1, 1'b1, 16'd100, 1'b1, 8'h40},  // R3 wrap
    '{8'd5,  8'd8, 1'b1, 1'b0, 16'd100, 1'b0, 8'h70},  // R5 near start
    '{8'd12, 8'd3, 1'b1, 1'b0, 16'd100, 1'b0, 8'h90},  // R6 near end
    '{8'd12, 8'd8, 1'b1, 1'b0, 16'd7,   1'b0, 8'hA0},  // R7 short
    '{8'd12, 8'd8, 1'b1, 1'b0, 16'd8,   1'b1, 8'hC0},  // R7 exact
    '{8'd10, 8'd0, 1'b0, 1'b0, 16'd100, 1'b0, 8'hE0},  // R6 no trigger
    '{8'd7,  8'd8, 1'b1, 1'b1, 16'd100, 1'b0, 8'h30}   // R5 one short
  };

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, smp_vld = 1'b0, trig = 1'b0, stop = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic [CW-1:0] main_count = '0;
  logic [AW-1:0] rd_ofs = '0;
  logic [DW-1:0] rd_data;
  logic done, valid;
  logic [AW-1:0] trig_index;
  int checks = 0, failures = 0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  snap_capture #(.DW(DW), .HALF(HALF), .CW(CW)) u_snap_capture (
    .clk(clk), .rst_n(rst_n), .arm(arm), .smp_vld(smp_vld), .smp_data(smp_data),
    .trig(trig), .stop(stop), .main_count(main_count), .rd_ofs(rd_ofs),
    .rd_data(rd_data), .done(done), .valid(valid), .trig_index(trig_index)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] d, input logic tg,
                      input logic st, input logic am);
    @(negedge clk);
    smp_vld = v; smp_data = d; trig = tg; stop = st; arm = am;
  endtask

  // R8: window offset j holds sample number t-HALF+j since arm
  task automatic check_read(input logic [7:0] seed, input int t);
    for (int j = 0; j < DEPTH; j++) begin
      rd_ofs = AW'(j);
      @(negedge clk);
      chk("R8 readback", rd_data, 32'(8'(seed + 8'(t - HALF + j))));
    end
  endtask

  task automatic run(input row_t r);
    int k = 0, t = 0;
    main_count = r.mcnt;
    step(0, 0, 0, 0, 1);
    for (int i = 0; i < int'(r.pre); i++) begin
      if (r.gap) step(0, 0, 0, 0, 0);
      step(1, 8'(r.seed + 8'(k)), 0, 0, 0);
      k++;
    end
    if (r.trg) begin
      t = k;
      step(1, 8'(r.seed + 8'(k)), 1, 0, 0);
      k++;
      for (int p = 1; p < int'(r.post); p++) begin
        if (p == HALF - 1 + 0 && 0) step(0, 0, 0, 0, 0);
        if (p == HALF - 1) begin
          step(0, 0, 0, 0, 0);
          step(0, 0, 0, 0, 0);
          chk("R4 done not early", done, 0);
        end
        if (r.gap) step(0, 0, 0, 0, 0);
        step(1, 8'(r.seed + 8'(k)), 0, 0, 0);
        k++;
      end
    end
    if (!r.trg || r.post < HALF) step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0);
    chk("R4/R6 done", done, 1);
    chk("R5/R6/R7 valid", valid, 32'(r.expv));
    if (r.trg) chk("R3 trig_index", trig_index, 32'(t % DEPTH));
    if (r.expv) check_read(r.seed, t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 valid", valid, 0);
    chk("R1 trig_index", trig_index, 0);
    rst_n = 1'b1;
    // R1: samples and triggers without arm are not taken
    step(1, 8'h77, 1, 0, 0);
    step(1, 8'h78, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R1 idle ignores", done, 0);

    foreach (ROWS[i]) run(ROWS[i]);

    // R9: after a valid capture, extra samples, triggers and stop are ignored
    run('{8'd9, 8'd8, 1'b1, 1'b0, 16'd50, 1'b1, 8'h55});
    step(1, 8'hEE, 1, 0, 0);
    step(1, 8'hEF, 0, 1, 0);
    step(1, 8'hF0, 1, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R9 done holds", done, 1);
    chk("R9 valid holds", valid, 1);
    chk("R9 trig_index holds", trig_index, 9);
    check_read(8'h55, 9);

    // R2: arm clears; re-arm mid-capture; sample in arm cycle dropped
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);
    chk("R2 done cleared", done, 0);
    chk("R10 valid cleared", valid, 0);
    for (int i = 0; i < 5; i++) step(1, 8'hAA, 0, 0, 0);
    step(1, 8'hFF, 0, 0, 1);
    for (int i = 0; i < 8; i++) step(1, 8'(8'h20 + 8'(i)), 0, 0, 0);
    // R3: trig without a sample is ignored
    step(0, 0, 1, 0, 0);
    for (int i = 8; i < 16; i++) step(1, 8'(8'h20 + 8'(i)), 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R3 bare trig ignored", done, 0);
    for (int i = 16; i < 24; i++) step(1, 8'(8'h20 + 8'(i)), i == 16, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R2 done after re-arm", done, 1);
    chk("R2 valid after re-arm", valid, 1);
    chk("R2 arm-cycle sample dropped", trig_index, 0);
    check_read(8'h20, 16);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule